// File: doc/BRIEF.md
# Refreshed Dynamic Scratchpad Register File

This block models a small register file built from dynamic storage. It holds eight rows, and each row is one 8-bit register pair made of two 4-bit halves. Bits [3:0] form the even nibble and bits [7:4] form the odd nibble. A processor-side port issues one access per clock slot. An access is either a 4-bit write, with a separate enable for each half, or a 4-bit read of one half.

Every access runs in two phases. In the first slot the request is captured: the row address, the nibble enables and the write data are held in a latch. That slot stands for the column precharge. In the second slot the decoded row is sensed. A read drives the selected half onto the output. A write is committed into the selected halves.

Dynamic cells lose their contents unless they are revisited, so the block has its own 3-bit refresh pointer. In any slot that the processor leaves free, the pointer's row is read and written back unchanged, and the pointer then moves to the next row. Each row has a retention timer. If a row goes too long without a refresh or a write, it is marked decayed. From then on, reads of that row return unknown data and raise an error flag.

Top module: `dram_scratchpad`

## Requirements
- R1: The 3-bit address selects exactly one of eight rows. A write changes only the addressed row, and all other rows keep their contents.
- R2: A write stores `acc_wdata` into bits [3:0] of the row when `acc_even_en` is 1, and into bits [7:4] when `acc_odd_en` is 1. Either half or both halves can be written. A half whose enable is 0 is left unchanged.
- R3: Write data is latched on the clock edge that accepts the request. Changing `acc_wdata` after that edge has no effect on what is stored.
- R4: A read accepted on edge N gives `rd_valid`=1 and `rd_data` after edge N+1, for one cycle. The data is bits [3:0] when the even enable is set, otherwise bits [7:4] when the odd enable is set, otherwise 0. The even half wins when both enables are set. A read that directly follows a write to the same row returns the new data. `rd_valid` is 0 in all other cycles.
- R5: A request with `acc_valid`=1 is accepted in every cycle, back to back, and always takes the slot ahead of refresh.
- R6: In every slot with `acc_valid`=0, the row under the refresh pointer is read and written back unchanged. The pointer then steps to the next row, wrapping from row 7 to row 0. A refresh that was deferred happens in the next free slot.
- R7: The retention timer of a row is cleared whenever that row is written or refreshed. If at least one slot in every `RETAIN_LIMIT`/8 cycles is free, no row ever decays and all data is kept for an unlimited time.
- R8: A row whose timer reaches `RETAIN_LIMIT` is marked decayed. A read of a decayed row returns unknown data with `decay_err`=1, in the same cycle as `rd_valid`. Only a write with both enables set clears the mark. A write of one half leaves the mark set.
- R9: After reset, `rd_valid`=0, `decay_err`=0, every row reads as 0, and no row is decayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Processor access request in this slot |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Row address |
| acc_even_en | input | 1 | Selects the even half, bits [3:0] |
| acc_odd_en | input | 1 | Selects the odd half, bits [7:4] |
| acc_wdata | input | NIB_W | Write data nibble |
| rd_valid | output | 1 | Read data is present |
| rd_data | output | NIB_W | Read data nibble |
| decay_err | output | 1 | The read row has decayed |

## Verification
A corrupted cell or a wrong row decode shows up at the next read of the affected row: the wrong nibble appears two edges after that read is accepted. A fault in the refresh pointer or in the retention timers is silent for much longer. It becomes visible only as `decay_err` on a read, and only after `RETAIN_LIMIT` cycles have passed without a correct refresh. For that reason, the bench holds long stretches of idle time and nearly saturated traffic before it reads every row back. The decay path is driven on purpose by keeping every slot busy beyond the limit.

// File: rtl/dram_pkg.sv
package dram_pkg;

    // Operation held in the sense stage for one slot
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2,
        OP_REFRESH = 2'd3
    } slot_op_e;

endpackage

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   en,
    output logic [(1<<ADDR_W)-1:0] row_oh
);
    localparam int ROWS = 1 << ADDR_W;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_comb begin
            row_oh[g] = en && (addr == ADDR_W'(g));
        end
    end

    always_comb begin
        assert (!en || $countones(row_oh) == 1)
            else $error("a_r1_decode_onehot: enabled decode not one-hot");
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    output logic              ref_go,
    output logic [ADDR_W-1:0] ref_row
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ref_state_t;

    ref_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        ref_go = !busy;
        if (ref_go) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_row = st_q.ptr;

    a_r6_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ref_go |=> st_q.ptr == $past(st_q.ptr) + ADDR_W'(1));

    a_r5_ptr_holds_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> st_q.ptr == $past(st_q.ptr));

endmodule

// File: rtl/dram_retention.sv
module dram_retention #(
    parameter int ROWS  = 8,
    parameter int LIMIT = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] touch,
    input  logic [ROWS-1:0] restore,
    output logic [ROWS-1:0] decayed
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    for (genvar g = 0; g < ROWS; g++) begin : g_cell
        typedef struct packed {
            logic [CNT_W-1:0] age;
            logic             dead;
        } ret_t;

        ret_t r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (touch[g]) begin
                r_d.age = '0;
            end else if (r_q.age != LIM) begin
                r_d.age = r_q.age + CNT_W'(1);
            end
            if (restore[g]) begin
                r_d.dead = 1'b0;
            end else if (r_q.age == LIM) begin
                r_d.dead = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign decayed[g] = r_q.dead;

        a_r7_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.age <= LIM);

        a_r8_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.age == LIM && !restore[g]) |=> r_q.dead);

        a_r7_touch_clears: assert property (@(posedge clk) disable iff (!rst_n)
            touch[g] |=> r_q.age == '0);
    end

endmodule

// File: rtl/dram_scratchpad.sv
module dram_scratchpad
    import dram_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int NIB_W        = 4,
    parameter int RETAIN_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_even_en,
    input  logic              acc_odd_en,
    input  logic [NIB_W-1:0]  acc_wdata,
    output logic              rd_valid,
    output logic [NIB_W-1:0]  rd_data,
    output logic              decay_err
);
    localparam int ROWS   = 1 << ADDR_W;
    localparam int PAIR_W = 2 * NIB_W;

    // Request captured in the precharge slot, used in the sense slot
    typedef struct packed {
        slot_op_e          op;
        logic [ADDR_W-1:0] row;
        logic              even;
        logic              odd;
        logic [NIB_W-1:0]  wlatch;
    } stage_t;

    typedef struct packed {
        logic [ROWS-1:0][PAIR_W-1:0] cells;
        stage_t                      stg;
        logic                        rd_valid;
        logic [NIB_W-1:0]            rd_data;
        logic                        decay_err;
    } state_t;

    state_t s_d, s_q;

    logic              ref_go;
    logic [ADDR_W-1:0] ref_row;
    logic [ROWS-1:0]   row_oh;
    logic [ROWS-1:0]   touch;
    logic [ROWS-1:0]   restore;
    logic [ROWS-1:0]   decayed;
    logic [PAIR_W-1:0] sensed;

    dram_refresh_ctrl #(.ADDR_W(ADDR_W)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (acc_valid),
        .ref_go (ref_go),
        .ref_row(ref_row)
    );

    dram_row_decoder #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (s_q.stg.row),
        .en    (s_q.stg.op != OP_NONE),
        .row_oh(row_oh)
    );

    dram_retention #(.ROWS(ROWS), .LIMIT(RETAIN_LIMIT)) u_retain (
        .clk    (clk),
        .rst_n  (rst_n),
        .touch  (touch),
        .restore(restore),
        .decayed(decayed)
    );

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            touch[r]   = row_oh[r] && (s_q.stg.op == OP_WRITE || s_q.stg.op == OP_REFRESH);
            restore[r] = row_oh[r] && s_q.stg.op == OP_WRITE && s_q.stg.even && s_q.stg.odd;
        end
    end

    always_comb begin
        s_d           = s_q;
        s_d.rd_valid  = 1'b0;
        s_d.rd_data   = '0;
        s_d.decay_err = 1'b0;

        // Sense: the decoded row is driven onto the column lines
        sensed = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_oh[r]) begin
                sensed = s_q.cells[r];
            end
        end

        case (s_q.stg.op)
            OP_READ: begin
                s_d.rd_valid = 1'b1;
                if (decayed[s_q.stg.row]) begin
                    s_d.rd_data   = 'x;
                    s_d.decay_err = 1'b1;
                end else if (s_q.stg.even) begin
                    s_d.rd_data = sensed[NIB_W-1:0];
                end else if (s_q.stg.odd) begin
                    s_d.rd_data = sensed[PAIR_W-1:NIB_W];
                end
            end
            OP_WRITE: begin
                for (int r = 0; r < ROWS; r++) begin
                    if (row_oh[r] && s_q.stg.even) begin
                        s_d.cells[r][NIB_W-1:0] = s_q.stg.wlatch;
                    end
                    if (row_oh[r] && s_q.stg.odd) begin
                        s_d.cells[r][PAIR_W-1:NIB_W] = s_q.stg.wlatch;
                    end
                end
            end
            OP_REFRESH: begin
                for (int r = 0; r < ROWS; r++) begin
                    if (row_oh[r]) begin
                        s_d.cells[r] = sensed;
                    end
                end
            end
            default: ;
        endcase

        // Precharge slot: capture the next request, or refresh if free
        if (acc_valid) begin
            s_d.stg.op   = acc_write ? OP_WRITE : OP_READ;
            s_d.stg.row  = acc_addr;
            s_d.stg.even = acc_even_en;
            s_d.stg.odd  = acc_odd_en;
            if (acc_write) begin
                s_d.stg.wlatch = acc_wdata;
            end
        end else if (ref_go) begin
            s_d.stg.op   = OP_REFRESH;
            s_d.stg.row  = ref_row;
            s_d.stg.even = 1'b1;
            s_d.stg.odd  = 1'b1;
        end else begin
            s_d.stg.op = OP_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid  = s_q.rd_valid;
    assign rd_data   = s_q.rd_data;
    assign decay_err = s_q.decay_err;

    a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |-> ##2 rd_valid);

    a_r8_err_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        decay_err |-> rd_valid);

    a_r2_even_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stg.op == OP_WRITE && s_q.stg.even)
        |=> s_q.cells[$past(s_q.stg.row)][NIB_W-1:0] == $past(s_q.stg.wlatch));

    a_r6_refresh_preserves: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stg.op == OP_REFRESH)
        |=> s_q.cells[$past(s_q.stg.row)] == $past(sensed));

    for (genvar g = 0; g < ROWS; g++) begin : g_chk
        a_r1_other_rows_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!row_oh[g] && $past(rst_n)) |=> s_q.cells[g] == $past(s_q.cells[g]));
    end

endmodule

// File: tb/dram_scratchpad_bench.sv
`timescale 1ns/1ps
module dram_scratchpad_bench;
    localparam int LIMIT = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [2:0] acc_addr = '0;
    logic       acc_even_en = 1'b0;
    logic       acc_odd_en = 1'b0;
    logic [3:0] acc_wdata = '0;
    logic       rd_valid;
    logic [3:0] rd_data;
    logic       decay_err;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    mon_en = 1'b0;
    string cur_req = "R9";
    logic [7:0] mdl [8];

    // Expected-read pipeline, captured at each accepting edge
    logic       p1_v = 1'b0, p2_v = 1'b0;
    logic [3:0] p1_d = '0, p2_d = '0;

    always #2.5 clk = ~clk;

    dram_scratchpad #(.ADDR_W(3), .NIB_W(4), .RETAIN_LIMIT(LIMIT)) u_dram_scratchpad (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_even_en(acc_even_en), .acc_odd_en(acc_odd_en),
        .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .decay_err(decay_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(input logic [2:0] a, input logic e, input logic o);
        if (e) return mdl[a][3:0];
        if (o) return mdl[a][7:4];
        return 4'h0;
    endfunction

    always @(posedge clk) begin
        p2_v = p1_v;
        p2_d = p1_d;
        p1_v = rst_n && acc_valid && !acc_write;
        p1_d = pick(acc_addr, acc_even_en, acc_odd_en);
    end

    // R4/R7: every output cycle compared while the monitor is on
    always @(negedge clk) begin
        if (mon_en) begin
            chk({cur_req, " rd_valid"}, 32'(rd_valid), 32'(p2_v));
            chk({cur_req, " decay_err R7"}, 32'(decay_err), 32'h0);
            if (p2_v) chk({cur_req, " rd_data"}, 32'(rd_data), 32'(p2_d));
        end
    end

    task automatic drive_idle();
        acc_valid = 1'b0; acc_write = 1'b0; acc_even_en = 1'b0; acc_odd_en = 1'b0;
    endtask

    task automatic drive_wr(input logic [2:0] a, input logic e, input logic o, input logic [3:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a;
        acc_even_en = e; acc_odd_en = o; acc_wdata = d;
        if (e) mdl[a][3:0] = d;
        if (o) mdl[a][7:4] = d;
    endtask

    task automatic drive_rd(input logic [2:0] a, input logic e, input logic o);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        acc_even_en = e; acc_odd_en = o;
    endtask

    task automatic idle(input int n);
        drive_idle();
        repeat (n) @(negedge clk);
    endtask

    task automatic read_all_rows();
        for (int r = 0; r < 8; r++) begin
            drive_rd(3'(r), 1'b1, 1'b0); @(negedge clk);
            drive_rd(3'(r), 1'b0, 1'b1); @(negedge clk);
        end
        idle(3);
    endtask

    task automatic t_reset();
        chk("R9 rd_valid after reset", 32'(rd_valid), 32'h0);
        chk("R9 decay_err after reset", 32'(decay_err), 32'h0);
        cur_req = "R9";
        mon_en = 1'b1;
        read_all_rows();
    endtask

    task automatic t_decode();
        cur_req = "R1";
        for (int r = 0; r < 8; r++) begin
            drive_wr(3'(r), 1'b1, 1'b1, 4'(r + 3)); @(negedge clk);
            drive_wr(3'(r), 1'b0, 1'b1, 4'(15 - r)); @(negedge clk);
        end
        idle(2);
        read_all_rows();
    endtask

    task automatic t_nibbles();
        cur_req = "R2";
        drive_wr(3'd2, 1'b1, 1'b0, 4'hA); @(negedge clk);
        drive_wr(3'd2, 1'b0, 1'b1, 4'h5); @(negedge clk);
        drive_rd(3'd2, 1'b1, 1'b0); @(negedge clk);
        drive_rd(3'd2, 1'b0, 1'b1); @(negedge clk);
        drive_wr(3'd2, 1'b0, 1'b1, 4'hC); @(negedge clk);
        drive_rd(3'd2, 1'b1, 1'b0); @(negedge clk);
        drive_rd(3'd2, 1'b0, 1'b1); @(negedge clk);
        drive_wr(3'd2, 1'b0, 1'b0, 4'h1); @(negedge clk);
        drive_rd(3'd2, 1'b1, 1'b0); @(negedge clk);
        drive_wr(3'd6, 1'b1, 1'b1, 4'h7); @(negedge clk);
        drive_rd(3'd6, 1'b0, 1'b1); @(negedge clk);
        idle(3);
    endtask

    task automatic t_latch();
        cur_req = "R3";
        drive_wr(3'd4, 1'b1, 1'b1, 4'h9); @(negedge clk);
        drive_idle(); acc_wdata = 4'h2; @(negedge clk);
        acc_wdata = 4'hF; @(negedge clk);
        drive_rd(3'd4, 1'b1, 1'b0); @(negedge clk);
        drive_rd(3'd4, 1'b0, 1'b1); @(negedge clk);
        idle(3);
    endtask

    task automatic t_read_forms();
        cur_req = "R4";
        drive_wr(3'd1, 1'b1, 1'b1, 4'h3); @(negedge clk);
        drive_wr(3'd1, 1'b0, 1'b1, 4'hE); @(negedge clk);
        drive_rd(3'd1, 1'b1, 1'b1); @(negedge clk);
        drive_rd(3'd1, 1'b0, 1'b0); @(negedge clk);
        drive_wr(3'd7, 1'b1, 1'b0, 4'hB); @(negedge clk);
        drive_rd(3'd7, 1'b1, 1'b0); @(negedge clk);
        idle(3);
    endtask

    task automatic t_idle_retention();
        cur_req = "R7";
        idle(5 * LIMIT);
        read_all_rows();
    endtask

    task automatic t_deferral();
        cur_req = "R5";
        for (int k = 0; k < 250; k++) begin
            for (int b = 0; b < 7; b++) begin
                drive_rd(3'(b), 1'b1, 1'b0); @(negedge clk);
            end
            idle(1);
        end
        idle(2);
        cur_req = "R6";
        read_all_rows();
    endtask

    task automatic t_random();
        logic [31:0] x = 32'h1234_5679;
        cur_req = "R2 random";
        for (int i = 0; i < 600; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            case (x[1:0])
                2'd0: drive_idle();
                2'd1: drive_wr(x[4:2], x[5], x[6], x[10:7]);
                default: drive_rd(x[4:2], x[5], x[6]);
            endcase
            @(negedge clk);
        end
        idle(3);
    endtask

    task automatic t_decay();
        mon_en = 1'b0;
        for (int i = 0; i < LIMIT + 30; i++) begin
            drive_rd(3'd0, 1'b1, 1'b0); @(negedge clk);
        end
        drive_rd(3'd3, 1'b1, 1'b0); @(negedge clk);
        drive_rd(3'd0, 1'b1, 1'b0); @(negedge clk);
        chk("R8 decayed read flags error", 32'(decay_err), 32'h1);
        chk("R8 decayed read valid", 32'(rd_valid), 32'h1);
        drive_wr(3'd3, 1'b1, 1'b0, 4'h9); @(negedge clk);
        drive_rd(3'd3, 1'b1, 1'b0); @(negedge clk);
        drive_rd(3'd0, 1'b1, 1'b0); @(negedge clk);
        chk("R8 half write keeps mark", 32'(decay_err), 32'h1);
        drive_wr(3'd3, 1'b1, 1'b1, 4'h6); @(negedge clk);
        drive_rd(3'd3, 1'b1, 1'b0); @(negedge clk);
        drive_rd(3'd3, 1'b0, 1'b1); @(negedge clk);
        chk("R8 full write clears mark", 32'(decay_err), 32'h0);
        chk("R8 data after full write even", 32'(rd_data), 32'h6);
        drive_idle(); @(negedge clk);
        chk("R8 data after full write odd", 32'(rd_data), 32'h6);
        for (int r = 0; r < 8; r++) begin
            drive_wr(3'(r), 1'b1, 1'b0, mdl[r][3:0]); @(negedge clk);
            drive_wr(3'(r), 1'b1, 1'b1, 4'(r)); @(negedge clk);
        end
        idle(3);
        cur_req = "R8";
        mon_en = 1'b1;
        read_all_rows();
    endtask

    initial begin
        for (int r = 0; r < 8; r++) mdl[r] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_nibbles();
        t_latch();
        t_read_forms();
        t_idle_retention();
        t_deferral();
        t_random();
        t_decay();
        mon_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R4 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule